// File: doc/BRIEF.md
# SD Card Command Line Engine

This block drives the command line of an SD card on behalf of a host. Software puts a 32-bit argument in one register and then writes a command word. The engine builds a 48-bit command frame with its CRC7 and shifts it out on the CMD pin. It can then skip the response, or collect a 48-bit short response or a 136-bit long one. It checks the CRC, the echoed index and the framing bits. When the exchange ends, it drops its command-busy flag.

The response check is chosen per command by flags in the command word, not from a table of response types. This lets one engine serve status replies, register dumps and replies that carry no valid CRC. A clock-mode field selects stop, a slow identification rate, or one of two fast rates. All rates are derived from the system clock by a half-period counter. Two status bits come from synchronised pins: card busy (the card holds DAT0 low) and card inserted (the card-detect input).

Register map (3-bit address): 0 control/status, 1 argument, 2 command word (a write starts a command), 4 to 7 response words 0 to 3. The register read port is combinational.

Top module: `sd_cmd_engine`

## Requirements
- R1: A write to address 2 starts a command. The word fields are: bits [5:0] index, bit 8 skip response, bit 9 long response, bit 10 ignore CRC, bit 11 ignore index. The engine sends the frame 0, 1, index, argument (address 1), CRC7 (x^7+x^3+1 over the first 40 bits), 1, most significant bit first. CMD changes only when the SD clock falls.
- R2: With the skip flag set, the engine releases CMD one SD clock after the end bit and finishes without an error.
- R3: A short response is 48 bits. Its bits [39:8] appear in response word 0 (address 4).
- R4: A long response is 136 bits. Its bits [127:0] fill the words at addresses 7, 6, 5 and 4, with address 7 the most significant.
- R5: The error bit (status bit 4) is set in any of these cases: the CRC7 of the response is wrong and ignore CRC is clear; the transmission bit is not 0; the end bit is not 1. The CRC covers response bits [47:8] of a short response and bits [127:8] of a long one.
- R6: When ignore index is clear, the error bit is set if the index field of the response differs from the command index. The index field is bits [45:40] of a short response and bits [133:128] of a long one.
- R7: After the end bit, the engine releases CMD. It ignores the next 2 rising SD clock edges and then samples up to 64 rising edges for a start bit. A start bit on the 64th sample is accepted. If none arrives, the error bit is set.
- R8: Command busy (status bit 2) reads 1 from the clock after the command write until the command completes. A command write made while busy is ignored. A new command clears the error bit. CMD is never driven while the engine is idle.
- R9: Status bit 3 reads 1 while DAT0 is low, two clocks after the pin changes.
- R10: Status bit 5 follows the card-detect input, two clocks after the pin changes.
- R11: Address 0 bits [1:0] select the clock mode: 0 stop, 1 slow, 2 mid, 3 fast. In stop mode the SD clock stays low. Modes 1, 2 and 3 give a period of twice SLOW_HALF, MID_HALF and FAST_HALF system clocks.
- R12: While the clock is stopped, a pending command makes no progress and stays busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| sdClk | output | 1 | SD clock |
| cmdOut | output | 1 | CMD output value |
| cmdOe | output | 1 | CMD output enable |
| cmdIn | input | 1 | CMD pin input |
| dat0In | input | 1 | DAT0 pin input (low means card busy) |
| cardDetect | input | 1 | Card-detect input, high means inserted |

## Verification
The assertions assume the card drives CMD only while the engine has released it. They also assume the card changes CMD only on falling SD clock edges, so the engine sees a settled value at each rising edge. The bench card model waits for a whole frame before it answers, then drives each bit right after a falling edge. Software is assumed not to change the clock mode during a command except to stop the clock. The stimulus does this only in the stop-mode test, which selects the mode before it writes the command.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [1:0] {
    CLK_OFF  = 2'd0,
    CLK_SLOW = 2'd1,
    CLK_MID  = 2'd2,
    CLK_FAST = 2'd3
  } clkMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // latch command, build frame, clear error
    logic drive;     // put next frame bit on CMD
    logic lineFree;  // release CMD
    logic sample;    // shift CMD input into the receive register
    logic crcUpd;    // fold sampled bit into running CRC
    logic capture;   // evaluate response, store words
    logic timeout;   // no start bit seen
  } dpCtrl_t;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_ARG  = 3'd1;
  localparam logic [2:0] ADDR_CMD  = 3'd2;

  localparam int FRAME_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int RSP_WORDS  = 4;

  function automatic logic [6:0] crc7Step(input logic [6:0] c, input logic b);
    logic fb;
    fb = c[6] ^ b;
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

endpackage

// File: rtl/sdc_clkgen.sv
module sdc_clkgen
  import sdc_pkg::*;
#(
  parameter int SLOW_HALF = 125,
  parameter int MID_HALF  = 2,
  parameter int FAST_HALF = 1
) (
  input  logic     clk,
  input  logic     rstN,
  input  clkMode_t mode,
  output logic     sdClk,
  output logic     riseTick,
  output logic     fallTick
);
  localparam int MAX_A = (SLOW_HALF > MID_HALF) ? SLOW_HALF : MID_HALF;
  localparam int MAX_H = (MAX_A > FAST_HALF) ? MAX_A : FAST_HALF;
  localparam int CW    = $clog2(MAX_H + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] halfLim;
  logic          wrap;

  always_comb begin
    unique case (mode)
      CLK_SLOW: halfLim = CW'(SLOW_HALF);
      CLK_MID:  halfLim = CW'(MID_HALF);
      CLK_FAST: halfLim = CW'(FAST_HALF);
      default:  halfLim = CW'(1);
    endcase
  end

  assign wrap     = (mode != CLK_OFF) && (cnt >= halfLim - 1'b1);
  assign riseTick = wrap && !sdClk;
  assign fallTick = wrap && sdClk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      sdClk <= 1'b0;
    end else if (mode == CLK_OFF) begin
      cnt   <= '0;
      sdClk <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      sdClk <= ~sdClk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sdc_control.sv
module sdc_control
  import sdc_pkg::*;
#(
  parameter int RSP_TIMEOUT = 64,
  parameter int TURN_CYCLES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    skipIn,
  input  logic    longIn,
  input  logic    riseTick,
  input  logic    fallTick,
  input  logic    cmdIn,
  output dpCtrl_t ctl,
  output logic    busy
);
  localparam int TW = $clog2(RSP_TIMEOUT + 1);
  localparam logic [7:0] TX_LEN    = 8'(FRAME_BITS);
  localparam logic [7:0] SHORT_LEN = 8'(FRAME_BITS);
  localparam logic [7:0] LONG_LEN  = 8'(LONG_BITS);
  localparam logic [7:0] TURN_LAST = 8'(TURN_CYCLES - 1);
  localparam logic [7:0] SHORT_CRC_END = 8'(FRAME_BITS - 9);
  localparam logic [7:0] LONG_CRC_BEG  = 8'd8;
  localparam logic [7:0] LONG_CRC_END  = 8'(LONG_BITS - 9);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_TURN, ST_WAIT, ST_RECV, ST_CHECK
  } state_t;

  state_t        state, nextState;
  logic [7:0]    bitCnt, nextCnt;
  logic [TW-1:0] waitCnt, nextWait;
  logic          skipQ, longQ;
  logic [7:0]    rxLen;

  assign rxLen = longQ ? LONG_LEN : SHORT_LEN;
  assign busy  = (state != ST_IDLE);

  always_comb begin
    nextState = state;
    nextCnt   = bitCnt;
    nextWait  = waitCnt;
    ctl       = '0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        ctl.load  = 1'b1;
        nextCnt   = '0;
        nextState = ST_SEND;
      end
      ST_SEND: if (fallTick) begin
        if (bitCnt == TX_LEN) begin
          ctl.lineFree = 1'b1;
          nextCnt      = '0;
          nextState    = skipQ ? ST_IDLE : ST_TURN;
        end else begin
          ctl.drive = 1'b1;
          nextCnt   = bitCnt + 1'b1;
        end
      end
      ST_TURN: if (riseTick) begin
        if (bitCnt == TURN_LAST) begin
          nextWait  = '0;
          nextState = ST_WAIT;
        end else begin
          nextCnt = bitCnt + 1'b1;
        end
      end
      ST_WAIT: if (riseTick) begin
        if (!cmdIn) begin
          ctl.sample = 1'b1;
          ctl.crcUpd = !longQ;
          nextCnt    = 8'd1;
          nextState  = ST_RECV;
        end else if (waitCnt == TW'(RSP_TIMEOUT - 1)) begin
          ctl.timeout = 1'b1;
          nextState   = ST_IDLE;
        end else begin
          nextWait = waitCnt + 1'b1;
        end
      end
      ST_RECV: if (riseTick) begin
        ctl.sample = 1'b1;
        ctl.crcUpd = longQ ? (bitCnt >= LONG_CRC_BEG && bitCnt <= LONG_CRC_END)
                           : (bitCnt <= SHORT_CRC_END);
        nextCnt    = bitCnt + 1'b1;
        if (bitCnt == rxLen - 1'b1) nextState = ST_CHECK;
      end
      ST_CHECK: begin
        ctl.capture = 1'b1;
        nextState   = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      waitCnt <= '0;
      skipQ   <= 1'b0;
      longQ   <= 1'b0;
    end else begin
      state   <= nextState;
      bitCnt  <= nextCnt;
      waitCnt <= nextWait;
      if (ctl.load) begin
        skipQ <= skipIn;
        longQ <= longIn;
      end
    end
  end
endmodule

// File: rtl/sdc_datapath.sv
module sdc_datapath
  import sdc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCtrl_t                    ctl,
  input  logic [5:0]                 cmdIdx,
  input  logic [31:0]                cmdArg,
  input  logic                       ignCrcIn,
  input  logic                       ignIdxIn,
  input  logic                       longIn,
  input  logic                       cmdIn,
  output logic                       cmdOut,
  output logic                       cmdOe,
  output logic [RSP_WORDS-1:0][31:0] rspWords,
  output logic                       errFlag
);
  logic [FRAME_BITS-1:0] txShift;
  logic [LONG_BITS-1:0]  rxShift;
  logic [6:0]            crcQ, txCrc, crcRx;
  logic [39:0]           txHead;
  logic [5:0]            idxQ, idxRx;
  logic                  ignCrcQ, ignIdxQ, longQ;
  logic [1:0]            hdrRx;
  logic                  rspBad;

  assign txHead = {2'b01, cmdIdx, cmdArg};

  always_comb begin
    txCrc = '0;
    for (int i = 39; i >= 0; i--) txCrc = crc7Step(txCrc, txHead[i]);
  end

  always_comb begin
    if (longQ) begin
      idxRx = rxShift[LONG_BITS-3 -: 6];
      hdrRx = rxShift[LONG_BITS-1 -: 2];
    end else begin
      idxRx = rxShift[FRAME_BITS-3 -: 6];
      hdrRx = rxShift[FRAME_BITS-1 -: 2];
    end
    crcRx  = rxShift[7:1];
    rspBad = (!ignCrcQ && (crcRx != crcQ)) ||
             (!ignIdxQ && (idxRx != idxQ)) ||
             (hdrRx != 2'b00) || !rxShift[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '0;
      rxShift  <= '0;
      crcQ     <= '0;
      idxQ     <= '0;
      ignCrcQ  <= 1'b0;
      ignIdxQ  <= 1'b0;
      longQ    <= 1'b0;
      cmdOut   <= 1'b1;
      cmdOe    <= 1'b0;
      rspWords <= '0;
      errFlag  <= 1'b0;
    end else begin
      if (ctl.load) begin
        txShift <= {txHead, txCrc, 1'b1};
        crcQ    <= '0;
        idxQ    <= cmdIdx;
        ignCrcQ <= ignCrcIn;
        ignIdxQ <= ignIdxIn;
        longQ   <= longIn;
        errFlag <= 1'b0;
      end
      if (ctl.drive) begin
        cmdOut  <= txShift[FRAME_BITS-1];
        cmdOe   <= 1'b1;
        txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
      end
      if (ctl.lineFree) begin
        cmdOut <= 1'b1;
        cmdOe  <= 1'b0;
      end
      if (ctl.sample) begin
        rxShift <= {rxShift[LONG_BITS-2:0], cmdIn};
        if (ctl.crcUpd) crcQ <= crc7Step(crcQ, cmdIn);
      end
      if (ctl.timeout) errFlag <= 1'b1;
      if (ctl.capture) begin
        errFlag <= rspBad;
        if (longQ) begin
          for (int w = 0; w < RSP_WORDS; w++) rspWords[w] <= rxShift[w*32 +: 32];
        end else begin
          rspWords[0] <= rxShift[39:8];
        end
      end
    end
  end
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sdc_pkg::*;
#(
  parameter int SLOW_HALF   = 125,
  parameter int MID_HALF    = 2,
  parameter int FAST_HALF   = 1,
  parameter int RSP_TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        sdClk,
  output logic        cmdOut,
  output logic        cmdOe,
  input  logic        cmdIn,
  input  logic        dat0In,
  input  logic        cardDetect
);
  clkMode_t                   modeQ;
  logic [31:0]                argQ, cmdWordQ;
  logic [1:0]                 dat0Sync, detSync;
  logic                       riseTick, fallTick, cmdBusy, errFlag, startReq;
  dpCtrl_t                    ctl;
  logic [RSP_WORDS-1:0][31:0] rspWords;

  assign startReq = regWe && (regAddr == ADDR_CMD) && !cmdBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= CLK_OFF;
      argQ     <= '0;
      cmdWordQ <= '0;
      dat0Sync <= 2'b11;
      detSync  <= 2'b00;
    end else begin
      dat0Sync <= {dat0Sync[0], dat0In};
      detSync  <= {detSync[0], cardDetect};
      if (regWe && regAddr == ADDR_CTRL) modeQ <= clkMode_t'(regWdata[1:0]);
      if (regWe && regAddr == ADDR_ARG)  argQ  <= regWdata;
      if (startReq)                      cmdWordQ <= regWdata;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr[2]) regRdata = rspWords[regAddr[1:0]];
    else begin
      unique case (regAddr[1:0])
        2'd0: regRdata = {26'd0, detSync[1], errFlag, !dat0Sync[1], cmdBusy, modeQ};
        2'd1: regRdata = argQ;
        2'd2: regRdata = cmdWordQ;
        default: regRdata = '0;
      endcase
    end
  end

  sdc_clkgen #(
    .SLOW_HALF(SLOW_HALF), .MID_HALF(MID_HALF), .FAST_HALF(FAST_HALF)
  ) u_clk (
    .clk(clk), .rstN(rstN), .mode(modeQ),
    .sdClk(sdClk), .riseTick(riseTick), .fallTick(fallTick)
  );

  sdc_control #(.RSP_TIMEOUT(RSP_TIMEOUT), .TURN_CYCLES(2)) u_ctl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .skipIn(regWdata[8]), .longIn(regWdata[9]),
    .riseTick(riseTick), .fallTick(fallTick), .cmdIn(cmdIn),
    .ctl(ctl), .busy(cmdBusy)
  );

  sdc_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .cmdIdx(regWdata[5:0]), .cmdArg(argQ),
    .ignCrcIn(regWdata[10]), .ignIdxIn(regWdata[11]), .longIn(regWdata[9]),
    .cmdIn(cmdIn), .cmdOut(cmdOut), .cmdOe(cmdOe),
    .rspWords(rspWords), .errFlag(errFlag)
  );
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sdClk,
  input logic       cmdOe,
  input logic       cmdOut,
  input logic       cmdBusy,
  input logic       errFlag,
  input logic [1:0] clkMode
);
  // R1: the first bit driven after the line is taken is the start bit
  a_r1_start_bit_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdOe) |-> !cmdOut);

  // R1: CMD holds while the SD clock rises
  a_r1_stable_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOe && $rose(sdClk)) |-> $stable(cmdOut));

  // R8: no drive on CMD while idle
  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !cmdBusy |-> !cmdOe);

  // R8: a fresh command starts with the error flag clear
  a_r8_new_cmd_clears_err: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdBusy) |-> !errFlag);

  // R11: stop mode keeps the SD clock low
  a_r11_stop_low: assert property (@(posedge clk) disable iff (!rstN)
    (clkMode == 2'd0) |=> !sdClk);

  // R12: a pending command does not advance while the clock is stopped
  a_r12_hold_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBusy && $past(cmdBusy) && clkMode == 2'd0 && $past(clkMode) == 2'd0) |=> cmdBusy);
endmodule

bind sd_cmd_engine sdc_checker u_chk (
  .clk(clk), .rstN(rstN), .sdClk(sdClk), .cmdOe(cmdOe), .cmdOut(cmdOut),
  .cmdBusy(cmdBusy), .errFlag(errFlag), .clkMode(modeQ)
);

// File: tb/tb_sd_cmd_engine.sv
module tb_sd_cmd_engine;
  localparam int SH = 6, MH = 3, FH = 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic sdClk, cmdOut, cmdOe, cmdIn;
  logic dat0In = 1'b1, cardDetect = 1'b0;
  logic cardOe = 1'b0, cardBit = 1'b1;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  assign cmdIn = cmdOe ? cmdOut : (cardOe ? cardBit : 1'b1);

  sd_cmd_engine #(.SLOW_HALF(SH), .MID_HALF(MH), .FAST_HALF(FH), .RSP_TIMEOUT(64)) dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .sdClk(sdClk), .cmdOut(cmdOut), .cmdOe(cmdOe), .cmdIn(cmdIn),
    .dat0In(dat0In), .cardDetect(cardDetect));

  // ---------------- card model ----------------
  logic         cardRespond = 0, cardLong = 0, cardActive = 0;
  int           cardDelay = 3;
  logic [135:0] cardRsp = '0;
  logic [47:0]  lastFrame = '0;
  int           frameCnt = 0;

  initial begin
    forever begin
      @(posedge sdClk);
      if (cmdOe && !cmdOut) begin
        cardActive = 1;
        lastFrame[47] = 1'b0;
        for (int i = 46; i >= 0; i--) begin
          @(posedge sdClk);
          lastFrame[i] = cmdOut;
        end
        frameCnt++;
        if (cardRespond) begin
          repeat (cardDelay) @(negedge sdClk);
          for (int j = (cardLong ? 135 : 47); j >= 0; j--) begin
            cardOe = 1'b1;
            cardBit = cardRsp[j];
            @(negedge sdClk);
          end
          cardOe = 1'b0;
          cardBit = 1'b1;
        end
        cardActive = 0;
      end
    end
  end

  function automatic logic [6:0] refCrc(input logic [135:0] v, input int hi, input int lo);
    logic [6:0] c = '0;
    for (int i = hi; i >= lo; i--) begin
      logic fb = c[6] ^ v[i];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'b0001001;
    end
    return c;
  endfunction

  task automatic check(input string tag, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitIdle(output logic [31:0] st);
    int n = 0;
    rd(3'd0, st);
    while (st[2] && n < 5000) begin rd(3'd0, st); n++; end
    while (cardActive && n < 10000) begin @(negedge clk); n++; end
  endtask

  task automatic measPeriod(output int per);
    int n = 0;
    per = 0;
    while (sdClk && n < 200) begin @(negedge clk); n++; end
    while (!sdClk && n < 200) begin @(negedge clk); n++; end
    while (sdClk && n < 200) begin @(negedge clk); n++; per++; end
    while (!sdClk && n < 200) begin @(negedge clk); n++; per++; end
    if (n >= 200) per = 0;
  endtask

  // ---------------- vector table ----------------
  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] arg;
    logic        skip, lng, ign, resv, respond;
    logic [7:0]  delay;
    logic        badCrc, badIdx, badEnd, expErr;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{6'd8,  32'h0000_01AA, 1'b0,1'b0,1'b0,1'b0,1'b1, 8'd3,  1'b0,1'b0,1'b0, 1'b0},
    '{6'd17, 32'hDEAD_BEEF, 1'b0,1'b0,1'b0,1'b0,1'b1, 8'd5,  1'b0,1'b0,1'b0, 1'b0},
    '{6'd0,  32'h0000_0000, 1'b1,1'b0,1'b0,1'b0,1'b0, 8'd3,  1'b0,1'b0,1'b0, 1'b0},
    '{6'd2,  32'h0000_0000, 1'b0,1'b1,1'b0,1'b1,1'b1, 8'd4,  1'b0,1'b0,1'b0, 1'b0},
    '{6'd9,  32'h1234_0000, 1'b0,1'b1,1'b0,1'b1,1'b1, 8'd3,  1'b1,1'b0,1'b0, 1'b1},
    '{6'd41, 32'h4030_0000, 1'b0,1'b0,1'b1,1'b1,1'b1, 8'd3,  1'b1,1'b0,1'b0, 1'b0},
    '{6'd55, 32'h5555_0000, 1'b0,1'b0,1'b0,1'b0,1'b1, 8'd3,  1'b0,1'b1,1'b0, 1'b1},
    '{6'd55, 32'h5555_0000, 1'b0,1'b0,1'b0,1'b1,1'b1, 8'd3,  1'b0,1'b1,1'b0, 1'b0},
    '{6'd3,  32'h0000_0000, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'd3,  1'b0,1'b0,1'b0, 1'b1},
    '{6'd13, 32'hA5A5_0001, 1'b0,1'b0,1'b0,1'b0,1'b1, 8'd66, 1'b0,1'b0,1'b0, 1'b0},
    '{6'd13, 32'hA5A5_0002, 1'b0,1'b0,1'b0,1'b0,1'b1, 8'd67, 1'b0,1'b0,1'b0, 1'b1},
    '{6'd10, 32'h7777_0000, 1'b0,1'b1,1'b0,1'b0,1'b1, 8'd3,  1'b0,1'b0,1'b0, 1'b1},
    '{6'd7,  32'h1234_0000, 1'b0,1'b0,1'b0,1'b0,1'b1, 8'd3,  1'b0,1'b0,1'b1, 1'b1},
    '{6'd16, 32'h0000_0200, 1'b0,1'b0,1'b0,1'b0,1'b1, 8'd3,  1'b0,1'b0,1'b0, 1'b0}
  };

  function automatic string tagOf(input vec_t v);
    if (v.respond && v.delay >= 8'd66 || (!v.respond && !v.skip)) return "R7";
    if (v.badIdx || (v.lng && !v.resv)) return "R6";
    if (v.badCrc || v.badEnd) return "R5";
    if (v.skip) return "R2";
    if (v.lng) return "R4";
    return "R3";
  endfunction

  logic [31:0] st, rv;
  int per, fc0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state (R8, R11)
    rd(3'd0, st);
    check("R8 reset status", st, 0);
    check("R8 reset line", {cmdOe, cmdOut}, 2'b01);
    check("R11 reset clock", sdClk, 0);

    // R10 card detect and R9 DAT0 busy
    cardDetect = 1'b1; dat0In = 1'b0;
    repeat (3) @(negedge clk);
    rd(3'd0, st);
    check("R10 inserted", st[5], 1);
    check("R9 card busy", st[3], 1);
    cardDetect = 1'b0; dat0In = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd0, st);
    check("R10 removed", st[5], 0);
    check("R9 card ready", st[3], 0);

    // R11 clock periods
    wr(3'd0, 32'd1); measPeriod(per); check("R11 slow period", per, 2*SH);
    wr(3'd0, 32'd0); wr(3'd0, 32'd2); measPeriod(per); check("R11 mid period", per, 2*MH);
    wr(3'd0, 32'd0); wr(3'd0, 32'd3); measPeriod(per); check("R11 fast period", per, 2*FH);

    // vector walk at fast clock
    for (int k = 0; k < NV; k++) begin
      vec_t v = VECS[k];
      logic [135:0] r = '0;
      logic [47:0] ef;
      logic [6:0] c;
      string tg = tagOf(v);
      if (v.lng) begin
        logic [127:0] body = {v.arg, ~v.arg, v.arg ^ 32'hA5A5_A5A5, v.arg + 32'd1};
        r = {2'b00, 6'h3F, body[127:8], 8'h00};
        c = refCrc(r, 127, 8) ^ {6'd0, v.badCrc};
      end else begin
        r[47:0] = {2'b00, v.idx ^ {5'd0, v.badIdx}, v.arg ^ 32'h5A5A_0F0F, 8'h00};
        c = refCrc(r, 47, 8) ^ {6'd0, v.badCrc};
      end
      r[7:1] = c;
      r[0] = ~v.badEnd;
      cardRsp = r; cardLong = v.lng; cardRespond = v.respond; cardDelay = int'(v.delay);
      fc0 = frameCnt;
      wr(3'd1, v.arg);
      wr(3'd2, {20'd0, v.resv, v.ign, v.lng, v.skip, 2'b00, v.idx});
      rd(3'd0, st);
      check("R8 busy after write", st[2], 1);
      waitIdle(st);
      check("R8 busy cleared", st[2], 0);
      check({tg, " error bit"}, st[4], v.expErr);
      ef = {2'b01, v.idx, v.arg, 8'h01};
      ef[7:1] = refCrc({88'd0, ef}, 47, 8);
      check("R1 frame count", frameCnt - fc0, 1);
      check("R1 frame bits", lastFrame, ef);
      check("R8 released", cmdOe, 0);
      if (v.respond && !v.expErr) begin
        if (v.lng) begin
          for (int w = 0; w < 4; w++) begin
            rd(3'(4 + w), rv);
            check("R4 long word", rv, r[w*32 +: 32]);
          end
        end else begin
          rd(3'd4, rv);
          check("R3 short payload", rv, r[39:8]);
        end
      end
    end

    // R8: a second command write while busy is ignored
    cardRespond = 1; cardLong = 0; cardDelay = 3;
    cardRsp = '0;
    cardRsp[47:0] = {2'b00, 6'd5, 32'h0BAD_F00D, 8'h01};
    cardRsp[7:1] = refCrc(cardRsp, 47, 8);
    fc0 = frameCnt;
    wr(3'd1, 32'h0000_1111);
    wr(3'd2, 32'h0000_0005);
    wr(3'd2, 32'h0000_0306);
    waitIdle(st);
    repeat (300) @(negedge clk);
    rd(3'd0, st);
    check("R8 second write ignored count", frameCnt - fc0, 1);
    check("R8 second write ignored index", lastFrame[45:40], 6'd5);
    check("R8 second write ignored idle", st[2], 0);

    // R12: stopped clock holds the command
    cardRespond = 0;
    fc0 = frameCnt;
    wr(3'd0, 32'd0);
    wr(3'd2, 32'h0000_0100);
    repeat (60) @(negedge clk);
    rd(3'd0, st);
    check("R12 still busy", st[2], 1);
    check("R12 no drive", {cmdOe, sdClk}, 2'b00);
    wr(3'd0, 32'd3);
    waitIdle(st);
    check("R12 completes after restart", {st[2], st[4]}, 2'b00);
    check("R2 skip frame sent", frameCnt - fc0, 1);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule